// File: doc/BRIEF.md
# Single-Wire Control Bus Message Transmitter

This block sends a message of one to sixteen bytes on a single-wire consumer-electronics control bus. Software fills a 16-entry byte buffer, writes a byte count, and writes a control word. The control word carries a retry limit, a broadcast flag, a start bit and a reset bit. The start bit and the reset bit both clear themselves. The block pulls the line low through an open-drain output (`cecOe` high means drive low) and reads the wired line back on `cecIn`.

Each message opens with one start bit. Each byte then goes out as one block: eight data bits MSB first, an end-of-message bit, and an acknowledge slot. All bit timing is counted in ticks of `TICK_DIV` clock cycles, and one tick is nominally 50 us.

The acknowledge slot works as follows:
- The transmitter drives a short low in the slot and then releases the line.
- It samples the line `ACK_SAMPLE` ticks after the falling edge.
- For a directly addressed message, a low sample is an acknowledge. For a broadcast message, a low sample means a follower rejected the block.

When a block is refused, the whole message is sent again from byte 0, up to the programmed number of retransmissions. After that the message is reported as failed.

Top module: `cec_tx_top`

## Requirements
- R1: After reset, the outputs read as follows: `ctrlRdata` = 0x10 (retry limit 1, broadcast 0, start 0, reset 0), `countRdata` = 0, and `busy`, `donePulse`, `doneFlag`, `failFlag` and `cecOe` are all 0.
- R2: `ctrlRdata` is laid out as {reset[7], retry limit[6:4], 2'b00[3:2], broadcast[1], start pending[0]}. Bits [3:2] always read 0 whatever is written to them. `countRdata` returns the written count.
- R3: A control write with bit 7 set does all of the following at the clock edge of the write. It stops any transfer, so `cecOe` and `busy` are 0 on the next cycle. It returns the retry limit, broadcast flag, start bit, count and both sticky flags to their reset values. Bit 7 then reads 1 for exactly one cycle and 0 afterwards.
- R4: A control write with bit 0 set starts a transfer. On the cycle after the start is taken, `busy` is 1 and start reads 0. Writing 0 to bit 0 has no effect.
- R5: A start bit is low for 74 ticks within a 90-tick period. A data 0 is low for 30 ticks and a data 1 is low for 12 ticks, both within a 48-tick period. Bits follow each other back to back.
- R6: Every block carries the byte MSB first, then an end-of-message bit, then the acknowledge slot. The end-of-message bit is 1 only in the last block. In the acknowledge slot the transmitter drives low for 12 ticks.
- R7: The block sends min(count,16) bytes, starting at buffer address 0. A count of 0 completes at once as a success, with no activity on the line.
- R8: For a directly addressed message (broadcast 0), a low line at the sample point means the block was acknowledged, and a high line means it failed.
- R9: For a broadcast message (broadcast 1), a high line at the sample point is success and a low line is rejection.
- R10: A refused block restarts the message, beginning with the start bit and byte 0, as long as fewer retransmissions than the retry limit have been made. Otherwise `failFlag` is set and the block goes idle. A message is therefore sent at most limit+1 times.
- R11: Every completion gives a `donePulse` exactly one cycle long. `doneFlag` is set on success and `failFlag` on failure, and both are cleared when the next start is taken. `busy` stays high from the start until the completion pulse.
- R12: While `busy` is high, control writes without bit 7, count writes and buffer writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 8 | Control word write data |
| ctrlRdata | output | 8 | Control word readback |
| countWe | input | 1 | Byte count write strobe |
| countWdata | input | 8 | Byte count write data |
| countRdata | output | 8 | Byte count readback |
| bufWe | input | 1 | Buffer write strobe |
| bufAddr | input | 4 | Buffer write address |
| bufWdata | input | 8 | Buffer write data |
| cecIn | input | 1 | Line level read back |
| cecOe | output | 1 | Pull line low when 1 |
| busy | output | 1 | Transfer in progress |
| donePulse | output | 1 | One-cycle completion pulse |
| doneFlag | output | 1 | Sticky success flag |
| failFlag | output | 1 | Sticky failure flag |

## Verification
The bench models a follower on the wire. It decodes every bit from the low width and period of `cecOe`, and it pulls the line low in the acknowledge slots it has chosen. The directed byte patterns are 0x00, 0xFF, 0xA5 and a full 16-byte random buffer. These patterns separate bit order, the two low widths, and the end-of-message marking on the last block. Refusal schedules are varied against the retry limit: a success after some refusals, a failure at limit 0, and a failure at a higher limit. These cases tell apart an off-by-one in the retry count and a wrong restart point. Sending the same schedules in broadcast mode shows whether the acknowledge sense is inverted. Counts of 0 and 20, and writes made while busy, cover the edges of the count and the ignore rule.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  typedef enum logic [1:0] {K_START, K_DATA, K_EOM, K_ACK} bitKind_t;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_EOM, ST_ACK} txState_t;
  typedef struct packed {
    logic     bitGo;
    bitKind_t kind;
    logic     clrByte;
    logic     nextByte;
    logic     clrBit;
    logic     incBit;
    logic     clrRetry;
    logic     incRetry;
  } txStrobe_t;
endpackage

// File: rtl/cec_tx_datapath.sv
module cec_tx_datapath
  import cec_tx_pkg::*;
#(
  parameter int TICK_DIV     = 5,
  parameter int START_LOW    = 74,
  parameter int START_PERIOD = 90,
  parameter int ZERO_LOW     = 30,
  parameter int ONE_LOW      = 12,
  parameter int BIT_PERIOD   = 48,
  parameter int ACK_SAMPLE   = 21,
  parameter int BUF_DEPTH    = 16,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int TW = $clog2(START_PERIOD + 1),
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clrAll,
  input  txStrobe_t     strb,
  input  logic          bufWe,
  input  logic [AW-1:0] bufAddr,
  input  logic [7:0]    bufWdata,
  input  logic          cecIn,
  input  logic          bcast,
  input  logic [2:0]    retryLim,
  input  logic [AW:0]   effCount,
  output logic          bitDone,
  output logic          ackOk,
  output logic          lastByte,
  output logic          lastBit,
  output logic          retryLeft,
  output logic          cecOe
);
  localparam logic [PW-1:0] TICK_LAST = PW'(TICK_DIV - 1);

  logic [7:0]    mem [BUF_DEPTH];
  logic [PW-1:0] preCnt;
  logic [TW-1:0] tmr, lowLen, period;
  logic          active, curOne, ackLine, tick;
  bitKind_t      curKind;
  logic [AW-1:0] byteIdx, nByte;
  logic [2:0]    bitCnt, nBit, retryCnt;
  logic          nxtOne;

  always_ff @(posedge clk) begin
    if (bufWe) mem[bufAddr] <= bufWdata;
  end

  // next position, as seen by a bit launched this cycle
  always_comb begin
    nByte = strb.clrByte ? '0 : (strb.nextByte ? byteIdx + 1'b1 : byteIdx);
    nBit  = strb.clrBit ? 3'd0 : (strb.incBit ? bitCnt + 3'd1 : bitCnt);
    nxtOne = (strb.kind == K_EOM) ? lastByte : mem[nByte][3'd7 - nBit];
  end

  always_comb begin
    unique case (curKind)
      K_START: lowLen = TW'(START_LOW);
      K_ACK:   lowLen = TW'(ONE_LOW);
      default: lowLen = curOne ? TW'(ONE_LOW) : TW'(ZERO_LOW);
    endcase
    period = (curKind == K_START) ? TW'(START_PERIOD) : TW'(BIT_PERIOD);
  end

  assign tick    = (preCnt == TICK_LAST);
  assign bitDone = active && tick && (tmr == period - 1'b1);
  assign cecOe   = active && (tmr < lowLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0; tmr <= '0; active <= 1'b0; curKind <= K_START;
      curOne <= 1'b0; ackLine <= 1'b1;
    end else if (clrAll) begin
      preCnt <= '0; tmr <= '0; active <= 1'b0; curKind <= K_START;
      curOne <= 1'b0; ackLine <= 1'b1;
    end else if (strb.bitGo) begin
      preCnt <= '0; tmr <= '0; active <= 1'b1;
      curKind <= strb.kind; curOne <= nxtOne;
    end else if (active) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) begin
        if (tmr == period - 1'b1) active <= 1'b0;
        else tmr <= tmr + 1'b1;
        if (curKind == K_ACK && tmr == TW'(ACK_SAMPLE - 1)) ackLine <= cecIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0; bitCnt <= '0; retryCnt <= '0;
    end else if (clrAll) begin
      byteIdx <= '0; bitCnt <= '0; retryCnt <= '0;
    end else begin
      byteIdx <= nByte;
      bitCnt  <= nBit;
      if (strb.clrRetry) retryCnt <= '0;
      else if (strb.incRetry) retryCnt <= retryCnt + 3'd1;
    end
  end

  assign lastByte  = ({1'b0, byteIdx} == effCount - 1'b1);
  assign lastBit   = (bitCnt == 3'd7);
  assign retryLeft = (retryCnt < retryLim);
  assign ackOk     = bcast ? ackLine : !ackLine;
endmodule

// File: rtl/cec_tx_fsm.sv
module cec_tx_fsm
  import cec_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clrAll,
  input  logic      startReq,
  input  logic      countZero,
  input  logic      bitDone,
  input  logic      ackOk,
  input  logic      lastByte,
  input  logic      lastBit,
  input  logic      retryLeft,
  output txStrobe_t strb,
  output logic      accept,
  output logic      busy,
  output logic      donePulse,
  output logic      doneFlag,
  output logic      failFlag
);
  txState_t state, nxt;
  logic finOk, finBad;

  always_comb begin
    nxt = state; strb = '0; accept = 1'b0; finOk = 1'b0; finBad = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        accept = 1'b1;
        if (countZero) finOk = 1'b1;
        else begin
          strb.bitGo = 1'b1; strb.kind = K_START;
          strb.clrByte = 1'b1; strb.clrBit = 1'b1; strb.clrRetry = 1'b1;
          nxt = ST_START;
        end
      end
      ST_START: if (bitDone) begin
        strb.bitGo = 1'b1; strb.kind = K_DATA; nxt = ST_DATA;
      end
      ST_DATA: if (bitDone) begin
        strb.bitGo = 1'b1;
        if (lastBit) begin strb.kind = K_EOM; nxt = ST_EOM; end
        else begin strb.kind = K_DATA; strb.incBit = 1'b1; end
      end
      ST_EOM: if (bitDone) begin
        strb.bitGo = 1'b1; strb.kind = K_ACK; nxt = ST_ACK;
      end
      ST_ACK: if (bitDone) begin
        if (!ackOk) begin
          if (retryLeft) begin
            strb.bitGo = 1'b1; strb.kind = K_START; strb.incRetry = 1'b1;
            strb.clrByte = 1'b1; strb.clrBit = 1'b1; nxt = ST_START;
          end else begin
            finBad = 1'b1; nxt = ST_IDLE;
          end
        end else if (lastByte) begin
          finOk = 1'b1; nxt = ST_IDLE;
        end else begin
          strb.bitGo = 1'b1; strb.kind = K_DATA;
          strb.nextByte = 1'b1; strb.clrBit = 1'b1; nxt = ST_DATA;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; donePulse <= 1'b0; doneFlag <= 1'b0; failFlag <= 1'b0;
    end else if (clrAll) begin
      state <= ST_IDLE; donePulse <= 1'b0; doneFlag <= 1'b0; failFlag <= 1'b0;
    end else begin
      state     <= nxt;
      donePulse <= finOk | finBad;
      if (accept) begin doneFlag <= 1'b0; failFlag <= 1'b0; end
      if (finOk)  doneFlag <= 1'b1;
      if (finBad) failFlag <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/cec_tx_top.sv
module cec_tx_top
  import cec_tx_pkg::*;
#(
  parameter int TICK_DIV     = 5,
  parameter int START_LOW    = 74,
  parameter int START_PERIOD = 90,
  parameter int ZERO_LOW     = 30,
  parameter int ONE_LOW      = 12,
  parameter int BIT_PERIOD   = 48,
  parameter int ACK_SAMPLE   = 21,
  parameter int BUF_DEPTH    = 16,
  localparam int AW = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWe,
  input  logic [7:0]    ctrlWdata,
  output logic [7:0]    ctrlRdata,
  input  logic          countWe,
  input  logic [7:0]    countWdata,
  output logic [7:0]    countRdata,
  input  logic          bufWe,
  input  logic [AW-1:0] bufAddr,
  input  logic [7:0]    bufWdata,
  input  logic          cecIn,
  output logic          cecOe,
  output logic          busy,
  output logic          donePulse,
  output logic          doneFlag,
  output logic          failFlag
);
  logic [2:0]  retryLim;
  logic        bcast, startReq, softRst, clrAll, accept;
  logic [7:0]  byteCount;
  logic [AW:0] effCount;
  logic        bitDone, ackOk, lastByte, lastBit, retryLeft;
  logic        unusedRsvd;
  txStrobe_t   strb;

  assign clrAll     = ctrlWe && ctrlWdata[7];
  assign unusedRsvd = ^ctrlWdata[3:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryLim <= 3'd1; bcast <= 1'b0; startReq <= 1'b0; byteCount <= '0; softRst <= 1'b0;
    end else if (clrAll) begin
      retryLim <= 3'd1; bcast <= 1'b0; startReq <= 1'b0; byteCount <= '0; softRst <= 1'b1;
    end else begin
      softRst <= 1'b0;
      if (ctrlWe && !busy) begin
        retryLim <= ctrlWdata[6:4];
        bcast    <= ctrlWdata[1];
        if (ctrlWdata[0]) startReq <= 1'b1;
      end
      if (countWe && !busy) byteCount <= countWdata;
      if (accept) startReq <= 1'b0;
    end
  end

  assign effCount   = (byteCount > 8'(BUF_DEPTH)) ? (AW+1)'(BUF_DEPTH) : byteCount[AW:0];
  assign ctrlRdata  = {softRst, retryLim, 2'b00, bcast, startReq};
  assign countRdata = byteCount;

  cec_tx_fsm i_fsm (
    .clk, .rstN, .clrAll, .startReq,
    .countZero(byteCount == 8'd0),
    .bitDone, .ackOk, .lastByte, .lastBit, .retryLeft,
    .strb, .accept, .busy, .donePulse, .doneFlag, .failFlag
  );

  cec_tx_datapath #(
    .TICK_DIV(TICK_DIV), .START_LOW(START_LOW), .START_PERIOD(START_PERIOD),
    .ZERO_LOW(ZERO_LOW), .ONE_LOW(ONE_LOW), .BIT_PERIOD(BIT_PERIOD),
    .ACK_SAMPLE(ACK_SAMPLE), .BUF_DEPTH(BUF_DEPTH)
  ) i_dp (
    .clk, .rstN, .clrAll, .strb,
    .bufWe(bufWe && !busy), .bufAddr, .bufWdata,
    .cecIn, .bcast, .retryLim, .effCount,
    .bitDone, .ackOk, .lastByte, .lastBit, .retryLeft, .cecOe
  );
endmodule

// File: rtl/cec_tx_checker.sv
module cec_tx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWe,
  input logic [7:0] ctrlWdata,
  input logic [7:0] ctrlRdata,
  input logic       busy,
  input logic       donePulse,
  input logic       doneFlag,
  input logic       failFlag,
  input logic       cecOe
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[3:2] == 2'b00);

  // R3
  rst_self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[7] |=> !ctrlRdata[7]);

  // R3
  rst_stops_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlWdata[7]) |=> (!cecOe && !busy));

  // R11
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R11
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(ctrlWe && ctrlWdata[7])) |-> donePulse);

  // R11
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneFlag && failFlag));

  // R5
  drive_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cecOe |-> busy);
endmodule

bind cec_tx_top cec_tx_checker i_chk (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
  .ctrlRdata(ctrlRdata), .busy(busy), .donePulse(donePulse),
  .doneFlag(doneFlag), .failFlag(failFlag), .cecOe(cecOe)
);

// File: tb/test_cec_tx_top.sv
module test_cec_tx_top;
  localparam int TD = 2;
  localparam int SL = 74, SP = 90, ZL = 30, OL = 12, BP = 48, HOLD = 30;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctrlWe = 0, countWe = 0, bufWe = 0;
  logic [7:0] ctrlWdata = 0, countWdata = 0, bufWdata = 0;
  logic [3:0] bufAddr = 0;
  logic [7:0] ctrlRdata, countRdata;
  logic cecIn, cecOe, busy, donePulse, doneFlag, failFlag;

  int nChecks = 0, nFail = 0;
  bit allDone = 0;
  logic [7:0] shadow [16];

  // follower / monitor state
  bit monClr = 0;
  int curBcast = 0, curRejBlk = 99, curNRej = 0;
  int pullCnt = 0, lowCnt = 0, gapCnt = 0, pos = 0, byteN = 0, attempts = 0, timingErr = 0;
  bit prevOe = 0, prevStart = 0, prevValid = 0;
  logic [7:0] shiftR = 0;
  logic eomR = 0;
  logic [7:0] capByte [16];
  logic capEom [16];

  assign cecIn = !(cecOe || (pullCnt != 0));

  always #5 clk = ~clk;

  cec_tx_top #(.TICK_DIV(TD)) i_cec_tx_top (
    .clk, .rstN, .ctrlWe, .ctrlWdata, .ctrlRdata, .countWe, .countWdata, .countRdata,
    .bufWe, .bufAddr, .bufWdata, .cecIn, .cecOe, .busy, .donePulse, .doneFlag, .failFlag
  );

  always @(negedge clk) begin
    if (monClr) begin
      pos = 0; byteN = 0; attempts = 0; timingErr = 0; prevValid = 0; pullCnt = 0;
    end
    if (pullCnt > 0) pullCnt = pullCnt - 1;
    if (cecOe && !prevOe) begin
      if (prevValid && gapCnt != (prevStart ? SP : BP) * TD) timingErr++;
      gapCnt = 1; lowCnt = 1;
      if (pos == 9) begin
        automatic bit rej = (byteN == curRejBlk) && (attempts <= curNRej);
        if (curBcast != 0 ? rej : !rej) pullCnt = HOLD * TD;
      end
    end else begin
      gapCnt++;
      if (cecOe) lowCnt++;
    end
    if (!cecOe && prevOe) begin
      prevValid = 1; prevStart = 0;
      if (lowCnt == SL * TD) begin
        attempts++; pos = 0; byteN = 0; prevStart = 1;
      end else if (lowCnt == ZL * TD || lowCnt == OL * TD) begin
        automatic bit b = (lowCnt == OL * TD);
        if (pos < 8) shiftR = {shiftR[6:0], b};
        else if (pos == 8) eomR = b;
        pos++;
        if (pos == 10) begin
          if (byteN < 16) begin capByte[byteN] = shiftR; capEom[byteN] = eomR; end
          byteN++; pos = 0;
        end
      end else timingErr++;
    end
    prevOe = cecOe;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    @(negedge clk); ctrlWe = 1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 0;
  endtask

  task automatic wrCount(input logic [7:0] v);
    @(negedge clk); countWe = 1; countWdata = v;
    @(negedge clk); countWe = 0;
  endtask

  task automatic wrBuf(input int a, input logic [7:0] d);
    @(negedge clk); bufWe = 1; bufAddr = 4'(a); bufWdata = d; shadow[a] = d;
    @(negedge clk); bufWe = 0;
  endtask

  task automatic startMsg(input int cnt, input bit bc, input int rl, input int nRej, input int rejBlk);
    curBcast = bc; curNRej = nRej; curRejBlk = rejBlk;
    wrCount(8'(cnt));
    @(negedge clk); monClr = 1; @(negedge clk); monClr = 0;
    wrCtrl({1'b0, 3'(rl), 2'b11, bc, 1'b1});
    @(negedge clk);
    if (cnt != 0) begin
      chk("R4 busy after start", int'(busy), 1);
      chk("R4 start self-clear", int'(ctrlRdata[0]), 0);
    end
  endtask

  task automatic finishMsg(input int cnt, input int rl, input int nRej, input int rejBlk, input string ackReq);
    automatic int eff = (cnt > 16) ? 16 : cnt;
    automatic int failN = (rejBlk < eff) ? nRej : 0;
    automatic bit ok = (failN <= rl);
    automatic int expAtt = (eff == 0) ? 0 : (ok ? failN + 1 : rl + 1);
    automatic int expN = ok ? eff : rejBlk + 1;
    automatic int w = 0;
    while (!donePulse && w < 40000) begin @(negedge clk); w++; end
    chk("R11 done pulse seen", int'(donePulse), 1);
    @(negedge clk);
    chk("R11 done pulse width", int'(donePulse), 0);
    chk("R11 busy low after done", int'(busy), 0);
    chk({ackReq, " doneFlag"}, int'(doneFlag), int'(ok));
    chk("R10 failFlag", int'(failFlag), int'(!ok));
    chk("R10 attempts", attempts, expAtt);
    chk("R7 blocks in last attempt", byteN, expN);
    chk("R5 bit timing errors", timingErr, 0);
    for (int k = 0; k < expN && k < 16; k++) begin
      chk("R6 byte value", int'(capByte[k]), int'(shadow[k]));
      chk("R6 end-of-message bit", int'(capEom[k]), int'(k == eff - 1));
    end
  endtask

  task automatic runMsg(input int cnt, input bit bc, input int rl, input int nRej, input int rejBlk, input string ackReq);
    startMsg(cnt, bc, rl, nRej, rejBlk);
    finishMsg(cnt, rl, nRej, rejBlk, ackReq);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!allDone) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c3c0));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk("R1 ctrl reset", int'(ctrlRdata), 8'h10);
    chk("R1 count reset", int'(countRdata), 0);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 flags reset", int'({donePulse, doneFlag, failFlag}), 0);
    chk("R1 line reset", int'(cecOe), 0);

    // R2 readback, reserved bits written as 1
    wrCtrl(8'h5E);
    chk("R2 ctrl readback", int'(ctrlRdata), 8'h52);
    wrCount(8'd37);
    chk("R2 count readback", int'(countRdata), 37);
    // R3 soft reset while idle
    wrCtrl(8'h80);
    chk("R3 reset bit pulse", int'(ctrlRdata[7]), 1);
    @(negedge clk);
    chk("R3 reset bit clears", int'(ctrlRdata), 8'h10);
    chk("R3 count cleared", int'(countRdata), 0);

    for (int i = 0; i < 16; i++) wrBuf(i, 8'($urandom));
    wrBuf(0, 8'hA5);
    // R8 single byte direct
    runMsg(1, 0, 1, 0, 99, "R8");
    wrBuf(0, 8'h00); wrBuf(1, 8'hFF);
    runMsg(2, 0, 0, 0, 99, "R8");
    // R7 full buffer and clamped count
    for (int i = 0; i < 16; i++) wrBuf(i, 8'($urandom));
    runMsg(16, 0, 1, 0, 99, "R7");
    runMsg(20, 0, 1, 0, 99, "R7");
    // R7 zero count
    runMsg(0, 0, 1, 0, 99, "R7");
    // R10 retries
    runMsg(3, 0, 5, 2, 1, "R10");
    runMsg(2, 0, 0, 1, 0, "R10");
    runMsg(2, 0, 2, 4, 1, "R10");
    // R9 broadcast
    runMsg(2, 1, 1, 0, 99, "R9");
    runMsg(2, 1, 1, 3, 0, "R9");
    runMsg(3, 1, 3, 1, 2, "R9");

    // R12 writes while busy ignored
    startMsg(2, 0, 1, 0, 99);
    wrCtrl(8'h73); wrCount(8'd9);
    @(negedge clk); bufWe = 1; bufAddr = 4'd1; bufWdata = ~shadow[1];
    @(negedge clk); bufWe = 0;
    finishMsg(2, 1, 0, 99, "R12");
    chk("R12 ctrl unchanged", int'(ctrlRdata), 8'h10);
    chk("R12 count unchanged", int'(countRdata), 2);

    // R3 soft reset mid-message
    startMsg(3, 1, 2, 0, 99);
    repeat (300) @(negedge clk);
    wrCtrl(8'h80);
    chk("R3 line released", int'(cecOe), 0);
    chk("R3 busy cleared", int'(busy), 0);
    chk("R3 reset pulse", int'(ctrlRdata[7]), 1);
    @(negedge clk);
    chk("R3 registers back to reset", int'(ctrlRdata), 8'h10);
    chk("R3 count back to reset", int'(countRdata), 0);
    chk("R3 flags cleared", int'({doneFlag, failFlag}), 0);
    repeat (200) @(negedge clk);
    chk("R3 line stays idle", int'(cecOe), 0);

    // constrained random
    for (int t = 0; t < 6; t++) begin
      automatic int cnt = 1 + int'($urandom % 3);
      automatic bit bc = 1'($urandom);
      automatic int rl = int'($urandom % 4);
      automatic int nr = int'($urandom % 3);
      automatic int rb = int'($urandom % cnt);
      for (int i = 0; i < cnt; i++) wrBuf(i, 8'($urandom));
      runMsg(cnt, bc, rl, nr, rb, bc ? "R9" : "R8");
    end

    allDone = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule